// File: doc/BRIEF.md
# Paired-Page Translation Lookaside Buffer

This block turns virtual addresses into physical addresses. It holds a set of entries that are all searched at the same time. Each entry covers two neighbouring virtual pages, one even and one odd. Each of the two pages has its own physical page number and its own valid bit. Each entry also has its own page size, from 1 KB up to 256 KB. A lookup gives a virtual address and the current address-space identifier. One cycle later the block returns a hit flag and the translated physical address.

Software fills the block through a write port. The entry written is either the one at a given index or the one chosen by a free-running victim counter. If a single lookup matches more than one entry, the block sets a sticky shutdown flag. From then on, every lookup misses until reset.

Top module: `pair_tlb`

## Requirements
- R1: Reset clears both valid bits of every entry, `shutdown`, `out_valid` and `out_hit`. Only reset clears `shutdown`.
- R2: `out_valid` is high in the cycle after a cycle with `lk_valid` high, and low otherwise.
- R3: An entry matches when `lk_va[31:11]` equals its stored VPN in every bit, except bits `lk_va[11+j]` where mask bit j is 1. The legal masks are 0x00, 0x03, 0x0F, 0x3F and 0xFF, for page sizes 1 KB, 4 KB, 16 KB, 64 KB and 256 KB.
- R4: One bit of `lk_va` chooses the half of the entry: 0 selects the even half and 1 selects the odd half. For mask 0 this bit is `lk_va[10]`; otherwise it is `lk_va[11+j]`, where j is the highest mask bit that is set.
- R5: On a hit, `out_pa` is built from two parts. It takes `lk_va[9:0]` and every `lk_va[10+j]` with mask bit j set. Every other bit comes from the selected physical page number shifted left by 10. On a miss, `out_pa` is 0.
- R6: A match also needs the stored identifier to equal `lk_asid`, unless the entry's global bit is 1.
- R7: If the selected half's valid bit is 0, that entry does not match.
- R8: A write with `wr_en` stores the entry at `wr_index`, or at the victim counter when `wr_random` is 1. The counter resets to 31 and drops by one every cycle. After reaching `RAND_LO` (default 4) it reloads 31.
- R9: A lookup in the same cycle as a write sees the entry contents from before the write.
- R10: A lookup that matches two or more entries reports a miss, and `shutdown` rises together with that result.
- R11: While `shutdown` is 1, every lookup misses, even one that matches exactly one entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Current address-space identifier |
| wr_en | input | 1 | Write one entry |
| wr_random | input | 1 | Use the victim counter instead of `wr_index` |
| wr_index | input | 5 | Explicit entry index |
| wr_vpn2 | input | 21 | VPN of the page pair (virtual address bits 31:11) |
| wr_mask | input | 8 | Page-size mask |
| wr_asid | input | 8 | Entry identifier |
| wr_global | input | 1 | Ignore the identifier on compare |
| wr_pfn0 | input | 22 | Even-page physical page number |
| wr_v0 | input | 1 | Even-page valid |
| wr_pfn1 | input | 22 | Odd-page physical page number |
| wr_v1 | input | 1 | Odd-page valid |
| out_valid | output | 1 | Lookup result valid |
| out_hit | output | 1 | Lookup hit |
| out_pa | output | 32 | Physical address |
| shutdown | output | 1 | Sticky multiple-match flag |

## Verification
Two events can fall in the same cycle: an entry refill and a lookup. The bench drives a write and a lookup together. Sometimes the lookup targets the address of the entry being overwritten, and sometimes it targets the victim slot of a random write. It then expects the old translation from that same lookup and a miss from the next one. A second coincidence is a multiple match and the shutdown it causes. The bench plants two identical entries and checks that the miss and the flag appear in the same result cycle.

// File: rtl/pair_tlb_pkg.sv
package pair_tlb_pkg;
  localparam int VA_W   = 32;
  localparam int PA_W   = 32;
  localparam int OFS_W  = 10;
  localparam int MASK_W = 8;
  localparam int ASID_W = 8;
  localparam int VPN2_W = VA_W - OFS_W - 1;
  localparam int PFN_W  = PA_W - OFS_W;

  typedef struct packed {
    logic [VPN2_W-1:0] vpn2;
    logic [MASK_W-1:0] mask;
    logic [ASID_W-1:0] asid;
    logic              glob;
    logic [PFN_W-1:0]  pfn0;
    logic              v0;
    logic [PFN_W-1:0]  pfn1;
    logic              v1;
  } tlb_entry_t;
endpackage

// File: rtl/pair_tlb_victim.sv
module pair_tlb_victim #(
  parameter int N_ENTRIES = 32,
  parameter int RAND_LO   = 4,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(N_ENTRIES - 1);
  localparam logic [IDX_W-1:0] LO  = IDX_W'(RAND_LO);

  always_ff @(posedge clk) begin
    if (rst)            idx <= TOP;
    else if (idx == LO) idx <= TOP;
    else                idx <= idx - 1'b1;
  end
endmodule

// File: rtl/pair_tlb_cmp.sv
module pair_tlb_cmp
  import pair_tlb_pkg::*;
(
  input  tlb_entry_t        ent,
  input  logic [VA_W-1:0]   va,
  input  logic [ASID_W-1:0] asid,
  output logic              hit,
  output logic [PFN_W-1:0]  pfn
);
  logic [VPN2_W-1:0] vmask;
  logic              tag_ok, asid_ok, odd;

  always_comb begin
    vmask   = {{(VPN2_W-MASK_W){1'b0}}, ent.mask};
    tag_ok  = ((va[VA_W-1:OFS_W+1] ^ ent.vpn2) & ~vmask) == '0;
    odd     = va[OFS_W];
    for (int j = 0; j < MASK_W; j++)
      if (ent.mask[j]) odd = va[OFS_W+1+j];
    asid_ok = ent.glob || (ent.asid == asid);
    hit     = tag_ok && asid_ok && (odd ? ent.v1 : ent.v0);
    pfn     = odd ? ent.pfn1 : ent.pfn0;
  end
endmodule

// File: rtl/pair_tlb_merge.sv
module pair_tlb_merge
  import pair_tlb_pkg::*;
#(
  parameter int N_ENTRIES = 32
) (
  input  logic [N_ENTRIES-1:0]             hits,
  input  logic [N_ENTRIES-1:0][PFN_W-1:0]  pfns,
  input  logic [N_ENTRIES-1:0][MASK_W-1:0] masks,
  output logic                             one,
  output logic                             multi,
  output logic [PFN_W-1:0]                 pfn,
  output logic [MASK_W-1:0]                mask
);
  logic seen;

  always_comb begin
    seen  = 1'b0;
    multi = 1'b0;
    pfn   = '0;
    mask  = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (hits[i]) begin
        if (seen) multi = 1'b1;
        seen = 1'b1;
        pfn  = pfn | pfns[i];
        mask = mask | masks[i];
      end
    end
    one = seen && !multi;
  end
endmodule

// File: rtl/pair_tlb.sv
module pair_tlb
  import pair_tlb_pkg::*;
#(
  parameter int N_ENTRIES = 32,
  parameter int RAND_LO   = 4,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              wr_en,
  input  logic              wr_random,
  input  logic [IDX_W-1:0]  wr_index,
  input  logic [VPN2_W-1:0] wr_vpn2,
  input  logic [MASK_W-1:0] wr_mask,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_global,
  input  logic [PFN_W-1:0]  wr_pfn0,
  input  logic              wr_v0,
  input  logic [PFN_W-1:0]  wr_pfn1,
  input  logic              wr_v1,
  output logic              out_valid,
  output logic              out_hit,
  output logic [PA_W-1:0]   out_pa,
  output logic              shutdown
);
  localparam int HI_W = PA_W - OFS_W - MASK_W;

  tlb_entry_t                             ents [N_ENTRIES];
  tlb_entry_t                             new_e;
  logic [IDX_W-1:0]                       rand_idx, widx;
  logic [N_ENTRIES-1:0]                   hits;
  logic [N_ENTRIES-1:0][PFN_W-1:0]        pfns;
  logic [N_ENTRIES-1:0][MASK_W-1:0]       masks;
  logic                                   one, multi;
  logic [PFN_W-1:0]                       sel_pfn;
  logic [MASK_W-1:0]                      sel_mask;
  logic [PA_W-1:0]                        ofs_mask, pa_c;

  pair_tlb_victim #(.N_ENTRIES(N_ENTRIES), .RAND_LO(RAND_LO)) u_victim (
    .clk(clk), .rst(rst), .idx(rand_idx)
  );

  assign widx  = wr_random ? rand_idx : wr_index;
  assign new_e = '{vpn2: wr_vpn2, mask: wr_mask, asid: wr_asid, glob: wr_global,
                   pfn0: wr_pfn0, v0: wr_v0, pfn1: wr_pfn1, v1: wr_v1};

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_ENTRIES; i++) begin
        ents[i].v0 <= 1'b0;
        ents[i].v1 <= 1'b0;
      end
    end else if (wr_en) begin
      ents[widx] <= new_e;
    end
  end

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    pair_tlb_cmp u_cmp (
      .ent(ents[g]), .va(lk_va), .asid(lk_asid), .hit(hits[g]), .pfn(pfns[g])
    );
    assign masks[g] = ents[g].mask;
  end

  pair_tlb_merge #(.N_ENTRIES(N_ENTRIES)) u_merge (
    .hits(hits), .pfns(pfns), .masks(masks),
    .one(one), .multi(multi), .pfn(sel_pfn), .mask(sel_mask)
  );

  assign ofs_mask = {{HI_W{1'b0}}, sel_mask, {OFS_W{1'b1}}};
  assign pa_c     = ({sel_pfn, {OFS_W{1'b0}}} & ~ofs_mask) | (lk_va[PA_W-1:0] & ofs_mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_pa    <= '0;
      shutdown  <= 1'b0;
    end else begin
      out_valid <= lk_valid;
      out_hit   <= 1'b0;
      out_pa    <= '0;
      if (lk_valid) begin
        if (multi) begin
          shutdown <= 1'b1;
        end else if (one && !shutdown) begin
          out_hit <= 1'b1;
          out_pa  <= pa_c;
        end
      end
    end
  end
endmodule

// File: rtl/pair_tlb_chk.sv
module pair_tlb_chk
  import pair_tlb_pkg::*;
#(
  parameter int N_ENTRIES = 32,
  parameter int RAND_LO   = 4,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input logic             clk,
  input logic             rst,
  input logic             lk_valid,
  input logic             out_valid,
  input logic             out_hit,
  input logic [PA_W-1:0]  out_pa,
  input logic             shutdown,
  input logic [IDX_W-1:0] rand_idx
);
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> out_valid);
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !out_valid);
  a_r2_hit_needs_valid: assert property (@(posedge clk) disable iff (rst)
    out_hit |-> out_valid);
  a_r5_miss_pa_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_hit) |-> (out_pa == '0));
  a_r1_shutdown_sticky: assert property (@(posedge clk) disable iff (rst)
    shutdown |=> shutdown);
  a_r10_rise_with_miss: assert property (@(posedge clk) disable iff (rst)
    $rose(shutdown) |-> (out_valid && !out_hit));
  a_r11_no_hit_when_down: assert property (@(posedge clk) disable iff (rst)
    shutdown |-> !out_hit);
  a_r8_victim_range: assert property (@(posedge clk) disable iff (rst)
    (int'(rand_idx) >= RAND_LO) && (int'(rand_idx) <= N_ENTRIES - 1));
endmodule

bind pair_tlb pair_tlb_chk #(.N_ENTRIES(N_ENTRIES), .RAND_LO(RAND_LO)) u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .out_valid(out_valid),
  .out_hit(out_hit), .out_pa(out_pa), .shutdown(shutdown), .rand_idx(rand_idx)
);

// File: tb/pair_tlb_tb.sv
`timescale 1ns/1ps
module pair_tlb_tb;
  import pair_tlb_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lk_valid = 1'b0, wr_en = 1'b0, wr_random = 1'b0;
  logic [31:0] lk_va = '0;
  logic [7:0]  lk_asid = '0;
  logic [4:0]  wr_index = '0;
  tlb_entry_t  wr_e = '0;
  logic        out_valid, out_hit, shutdown;
  logic [31:0] out_pa;

  int n_chk = 0, n_fail = 0;
  int rand_m = 31;
  bit sd_m = 1'b0;
  tlb_entry_t m [32];

  always #5 clk = ~clk;

  pair_tlb u_dut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_va(lk_va), .lk_asid(lk_asid),
    .wr_en(wr_en), .wr_random(wr_random), .wr_index(wr_index),
    .wr_vpn2(wr_e.vpn2), .wr_mask(wr_e.mask), .wr_asid(wr_e.asid),
    .wr_global(wr_e.glob), .wr_pfn0(wr_e.pfn0), .wr_v0(wr_e.v0),
    .wr_pfn1(wr_e.pfn1), .wr_v1(wr_e.v1),
    .out_valid(out_valid), .out_hit(out_hit), .out_pa(out_pa), .shutdown(shutdown)
  );

  // victim counter expected per R8
  always @(posedge clk) begin
    if (rst) rand_m <= 31;
    else     rand_m <= (rand_m == 4) ? 31 : rand_m - 1;
  end

  task automatic check(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] size_mask(input int k);
    return 8'((1 << (2 * k)) - 1);
  endfunction

  function automatic tlb_entry_t mk(input logic [20:0] vpn, input logic [7:0] msk,
      input logic [7:0] as, input bit g, input logic [21:0] p0, input bit v0,
      input logic [21:0] p1, input bit v1);
    tlb_entry_t e;
    e.vpn2 = vpn; e.mask = msk; e.asid = as; e.glob = g;
    e.pfn0 = p0; e.v0 = v0; e.pfn1 = p1; e.v1 = v1;
    return e;
  endfunction

  // address inside the entry's pair; optionally force the half-select bit (R4)
  function automatic logic [31:0] mkva(input tlb_entry_t e, input bit force_h, input bit oddv);
    logic [31:0] va;
    int pos;
    va  = {e.vpn2, 11'b0} | ($urandom & {13'b0, e.mask, 11'h7FF});
    pos = 10;
    for (int j = 0; j < 8; j++) if (e.mask[j]) pos = 11 + j;
    if (force_h) va[pos] = oddv;
    return va;
  endfunction

  // expected translation from R3..R7
  task automatic mlook(input logic [31:0] va, input logic [7:0] as,
                       output logic [31:0] pa, output int cnt);
    cnt = 0; pa = '0;
    for (int i = 0; i < 32; i++) begin
      tlb_entry_t e;
      bit tag, odd, ok;
      logic [31:0] om;
      logic [21:0] pf;
      e   = m[i];
      tag = ((va[31:11] ^ e.vpn2) & ~{13'b0, e.mask}) == 21'b0;
      odd = va[10];
      for (int j = 0; j < 8; j++) if (e.mask[j]) odd = va[11 + j];
      ok  = tag && (e.glob || e.asid == as) && (odd ? e.v1 : e.v0);
      if (ok) begin
        cnt++;
        pf = odd ? e.pfn1 : e.pfn0;
        om = {14'b0, e.mask, 10'h3FF};
        pa = ({pf, 10'b0} & ~om) | (va & om);
      end
    end
  endtask

  // one cycle: optional write and optional lookup, driven at a falling edge
  task automatic op(input bit dw, input bit rnd, input int idx, input tlb_entry_t e,
                    input bit dl, input logic [31:0] va, input logic [7:0] as,
                    input string req);
    logic [31:0] pa;
    int cnt, tgt;
    bit exp_hit, sd_n;
    mlook(va, as, pa, cnt);
    exp_hit = dl && cnt == 1 && !sd_m;
    sd_n    = sd_m || (dl && cnt >= 2);
    tgt     = rnd ? rand_m : idx;
    wr_en = dw; wr_random = rnd; wr_index = 5'(idx); wr_e = e;
    lk_valid = dl; lk_va = va; lk_asid = as;
    @(negedge clk);
    wr_en = 1'b0; lk_valid = 1'b0;
    if (dw) m[tgt] = e;
    sd_m = sd_n;
    check(req, "out_valid", 64'(out_valid), 64'(dl));
    if (dl) begin
      check(req, "out_hit", 64'(out_hit), 64'(exp_hit));
      check(req, "out_pa", 64'(out_pa), exp_hit ? 64'(pa) : 64'd0);
    end
    check(req, "shutdown", 64'(shutdown), 64'(sd_m));
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 32; i++) m[i] = '0;
    sd_m = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    tlb_entry_t e, e2;
    logic [31:0] va;
    int t;
    void'($urandom(32'h5eed_71b));
    do_reset();

    // R1 reset state
    check("R1", "out_valid", 64'(out_valid), 64'd0);
    check("R1", "out_hit", 64'(out_hit), 64'd0);
    check("R1", "shutdown", 64'(shutdown), 64'd0);
    op(0, 0, 0, '0, 1, 32'h0, 8'h0, "R1");

    // R3/R4/R5: every page size, both halves
    for (int k = 0; k < 5; k++) begin
      e = mk({13'(k + 1), 8'h00}, size_mask(k), 8'h05, 1'b0,
             22'($urandom), 1'b1, 22'($urandom), 1'b1);
      op(1, 0, k, e, 0, 0, 0, "R8");
      op(0, 0, 0, e, 1, mkva(e, 1, 0), 8'h05, "R4");
      op(0, 0, 0, e, 1, mkva(e, 1, 1), 8'h05, "R5");
      op(0, 0, 0, e, 1, mkva(e, 0, 0) ^ 32'h8000_0000, 8'h05, "R3");
    end

    // R6 identifier compare and global bit
    op(0, 0, 0, e, 1, mkva(m[2], 0, 0), 8'h06, "R6");
    e = mk({13'h40, 8'h00}, 8'h0F, 8'h11, 1'b1, 22'h2AAAA, 1'b1, 22'h15555, 1'b1);
    op(1, 0, 5, e, 0, 0, 0, "R6");
    op(0, 0, 0, e, 1, mkva(e, 0, 0), 8'hEE, "R6");

    // R7 invalid half
    e = mk({13'h41, 8'h00}, 8'h03, 8'h05, 1'b0, 22'h111, 1'b1, 22'h222, 1'b0);
    op(1, 0, 6, e, 0, 0, 0, "R7");
    op(0, 0, 0, e, 1, mkva(e, 1, 1), 8'h05, "R7");
    op(0, 0, 0, e, 1, mkva(e, 1, 0), 8'h05, "R7");

    // fill all slots, then R8 random writes replace the victim slot
    for (int i = 0; i < 32; i++) begin
      e = mk({13'(100 + i), 8'h00}, 8'h00, 8'h01, 1'b0,
             22'($urandom), 1'b1, 22'($urandom), 1'b1);
      op(1, 0, i, e, 0, 0, 0, "R8");
    end
    for (int n = 0; n < 6; n++) begin
      t  = rand_m;
      e2 = m[t];
      e  = mk({13'(200 + n), 8'h00}, 8'h00, 8'h01, 1'b0,
              22'($urandom), 1'b1, 22'($urandom), 1'b1);
      op(1, 1, 0, e, 0, 0, 0, "R8");
      op(0, 0, 0, e, 1, mkva(e2, 0, 0), 8'h01, "R8");
      op(0, 0, 0, e, 1, mkva(e, 0, 0), 8'h01, "R8");
    end

    // R9 write and lookup together: old contents seen, then gone
    e2 = m[3];
    va = mkva(e2, 0, 0);
    e  = mk({13'h77, 8'h00}, 8'h00, 8'h01, 1'b0, 22'h3, 1'b1, 22'h4, 1'b1);
    op(1, 0, 3, e, 1, va, e2.asid, "R9");
    op(0, 0, 0, e, 1, va, e2.asid, "R9");
    t  = rand_m;
    e2 = m[t];
    va = mkva(e2, 0, 0);
    op(1, 1, 0, mk({13'h78, 8'h00}, 8'h00, 8'h01, 1'b0, 22'h5, 1'b1, 22'h6, 1'b1),
       1, va, e2.asid, "R9");
    op(0, 0, 0, e, 1, va, e2.asid, "R9");

    // constrained random mix, entries unique per slot
    for (int n = 0; n < 600; n++) begin
      if ($urandom % 2 == 0) begin
        bit rnd;
        rnd = 1'($urandom);
        t   = rnd ? rand_m : int'($urandom % 32);
        e   = mk({13'(300 + t), 8'($urandom)}, size_mask(int'($urandom % 5)),
                 8'($urandom % 4), 1'($urandom % 4 == 0),
                 22'($urandom), 1'($urandom % 4 != 0), 22'($urandom), 1'($urandom % 4 != 0));
        op(1, rnd, t, e, 1'($urandom), mkva(m[$urandom % 32], 0, 0), 8'($urandom % 4), "R9");
      end else begin
        e = m[$urandom % 32];
        op(0, 0, 0, e, 1, mkva(e, 0, 0), 8'($urandom % 4), "R3");
      end
    end

    // R10 multiple match, R11 shutdown forces misses
    e = mk({13'h1FFF, 8'h00}, 8'h00, 8'h09, 1'b0, 22'h10, 1'b1, 22'h20, 1'b1);
    op(1, 0, 0, e, 0, 0, 0, "R10");
    op(1, 0, 1, e, 0, 0, 0, "R10");
    e2 = mk({13'h1FFE, 8'h00}, 8'h00, 8'h09, 1'b0, 22'h30, 1'b1, 22'h40, 1'b1);
    op(1, 0, 2, e2, 0, 0, 0, "R11");
    op(0, 0, 0, e2, 1, mkva(e2, 0, 0), 8'h09, "R11");
    op(0, 0, 0, e, 1, mkva(e, 0, 0), 8'h09, "R10");
    check("R10", "shutdown_now", 64'(shutdown), 64'd1);
    op(0, 0, 0, e2, 1, mkva(e2, 0, 0), 8'h09, "R11");
    check("R11", "hit_blocked", 64'(out_hit), 64'd0);
    repeat (5) op(0, 0, 0, e2, 0, 0, 0, "R11");

    // R1 reset clears shutdown and valid bits
    do_reset();
    check("R1", "shutdown_cleared", 64'(shutdown), 64'd0);
    op(0, 0, 0, e2, 1, mkva(e2, 0, 0), 8'h09, "R1");

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule